// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

This block is a clocked model of a word-organised static memory whose control pins use active-low, asynchronous-style levels. The pins are a select, a write strobe, a read enable and one enable per byte lane. A system clock that runs well above the access rate samples these levels. The decoder sorts every sample into one of four operating modes: idle, outputs off, read or write. Each byte lane is then gated on its own for storing and for driving.

The bidirectional data pins of a discrete part are split here into three parts: a write-data bus, a read-data bus, and a per-lane drive flag that a pad ring or board model would use as its tristate enable. A lane whose flag is low is treated as high impedance and reads as zero on the read bus. An idle flag marks the deselected, low-power state.

The array depth is set by `ADDR_W`. With `ADDR_W = 16` the core holds 65,536 words of 16 bits. The default of 11 keeps elaboration small.

Top module: `bytelane_sram`

## Requirements
- R1: Every one of the 2^ADDR_W word locations is stored on its own, and a read returns the last value written to that address, including the highest address.
- R2: With `sel_n` high, `op_mode` is 0 (idle), `idle_pwr` is 1, no lane is driven and nothing is written, whatever the other inputs are.
- R3: With `sel_n` and `wr_n` low and at least one lane enable low, `op_mode` is 3 (write), no lane is driven, and `rden_n` has no effect.
- R4: In a write, `lane_en_n[0]` low stores `wdata[7:0]` and `lane_en_n[1]` low stores `wdata[15:8]`; a lane whose enable is high keeps its old contents.
- R5: A lane commits data once, in the first sampled cycle of its overlap of select, write strobe and lane enable. While that overlap stays unbroken, later changes of address or data write nothing more.
- R6: With `sel_n` low, `wr_n` high and `rden_n` low, `op_mode` is 2 (read). Lane i is driven, with its stored byte, exactly when `lane_en_n[i]` is low. The bits of an undriven lane read as 0.
- R7: With `sel_n` low and either both lane enables high, or both `wr_n` and `rden_n` high, `op_mode` is 1 (outputs off), no lane is driven and nothing is written.
- R8: All outputs reflect the inputs sampled two rising clock edges earlier. A read sampled on the edge after a write's commit returns the new data.
- R9: The synchronous, active-high `rst` sets `op_mode` to 0, `idle_pwr` to 1, `lane_drv` to 0 and `rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rden_n | input | 1 | Read output enable, active low |
| lane_en_n | input | LANES (2) | Byte lane enables, active low; bit 0 covers bits 7:0 |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data; undriven lanes read zero |
| lane_drv | output | LANES | Per-lane drive flag (tristate enable) |
| op_mode | output | 2 | 0 idle, 1 outputs off, 2 read, 3 write |
| idle_pwr | output | 1 | Deselected, low-power indication |

## Verification
The bench aims at several ways the decode could go wrong.

- Deselected writes, and writes with both lane enables high, must not store anything. A decoder that let the write strobe win over select or lane enables would corrupt the stored word, and a later readback shows it.
- An unbroken write overlap that walks across addresses must store only its first word. An implementation that writes on every cycle of the overlap would overwrite the second address.
- One lane may join an overlap late. If edge detection were shared across lanes instead of kept per lane, that lane's byte would never be stored.
- Single-lane reads, and writes held with the read enable low, expose any decode that drives a lane it should leave in high impedance.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_OFF  = 2'd1,
    MODE_RD   = 2'd2,
    MODE_WR   = 2'd3
  } bls_mode_e;
endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic             rden_n,
  input  logic [LANES-1:0] lane_en_n,
  output bls_mode_e        mode,
  output logic [LANES-1:0] drv,
  output logic [LANES-1:0] ovl
);
  // Priority: select, then lane enables, then write strobe, then read enable.
  always_comb begin
    if (sel_n)             mode = MODE_IDLE;
    else if (&lane_en_n)   mode = MODE_OFF;
    else if (!wr_n)        mode = MODE_WR;
    else if (!rden_n)      mode = MODE_RD;
    else                   mode = MODE_OFF;
  end

  always_comb begin
    drv = (mode == MODE_RD) ? ~lane_en_n : '0;
    ovl = (!sel_n && !wr_n) ? ~lane_en_n : '0;
  end
endmodule

// File: rtl/bls_lane_mem.sv
module bls_lane_mem #(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // Read-first single-port array, suitable for block RAM inference.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              rden_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  lane_drv,
  output logic [1:0]        op_mode,
  output logic              idle_pwr
);
  // Input sampling stage
  logic              s_sel_n, s_wr_n, s_rden_n;
  logic [LANES-1:0]  s_len_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_sel_n  <= 1'b1;
      s_wr_n   <= 1'b1;
      s_rden_n <= 1'b1;
      s_len_n  <= '1;
      s_addr   <= '0;
      s_wdata  <= '0;
    end else begin
      s_sel_n  <= sel_n;
      s_wr_n   <= wr_n;
      s_rden_n <= rden_n;
      s_len_n  <= lane_en_n;
      s_addr   <= addr;
      s_wdata  <= wdata;
    end
  end

  // Mode decode
  bls_mode_e        dec_mode;
  logic [LANES-1:0] dec_drv, dec_ovl;

  bls_decode #(.LANES(LANES)) u_dec (
    .sel_n     (s_sel_n),
    .wr_n      (s_wr_n),
    .rden_n    (s_rden_n),
    .lane_en_n (s_len_n),
    .mode      (dec_mode),
    .drv       (dec_drv),
    .ovl       (dec_ovl)
  );

  // Per-lane commit on the first cycle of each overlap
  logic [LANES-1:0] ovl_prev;
  logic [LANES-1:0] commit;

  always_ff @(posedge clk) begin
    if (rst) ovl_prev <= '0;
    else     ovl_prev <= dec_ovl;
  end

  assign commit = dec_ovl & ~ovl_prev;

  // Registered outputs
  bls_mode_e        mode_q;
  logic [LANES-1:0] drv_q;
  logic             idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
      drv_q  <= '0;
      idle_q <= 1'b1;
    end else begin
      mode_q <= dec_mode;
      drv_q  <= dec_drv;
      idle_q <= (dec_mode == MODE_IDLE);
    end
  end

  // Byte lane arrays
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;

    bls_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk  (clk),
      .we   (commit[g]),
      .addr (s_addr),
      .wd   (s_wdata[g*LANE_W +: LANE_W]),
      .rd   (lane_q)
    );

    assign rdata[g*LANE_W +: LANE_W] = lane_q & {LANE_W{drv_q[g]}};
  end

  assign lane_drv = drv_q;
  assign op_mode  = mode_q;
  assign idle_pwr = idle_q;
endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_n,
  input logic             wr_n,
  input logic [LANES-1:0] lane_en_n,
  input logic [LANES-1:0] lane_drv,
  input logic [1:0]       op_mode,
  input logic             idle_pwr
);
  // Edges seen since reset release, saturating at 2
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)           warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    idle_pwr |-> (lane_drv == '0)); // R2

  AST_IDLE_FLAG_MODE: assert property (@(posedge clk) disable iff (rst)
    idle_pwr == (op_mode == 2'd0)); // R2

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((warm == 2'd2) && $past(sel_n, 2)) |-> idle_pwr); // R2

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 2'd3) |-> (lane_drv == '0)); // R3

  AST_WRITE_MODE: assert property (@(posedge clk) disable iff (rst)
    ((warm == 2'd2) && !$past(sel_n, 2) && !$past(wr_n, 2) && !(&$past(lane_en_n, 2)))
      |-> (op_mode == 2'd3)); // R3

  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    (lane_drv != '0) |-> (op_mode == 2'd2)); // R6
endmodule

bind bytelane_sram bls_checker #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel_n     (sel_n),
  .wr_n      (wr_n),
  .lane_en_n (lane_en_n),
  .lane_drv  (lane_drv),
  .op_mode   (op_mode),
  .idle_pwr  (idle_pwr)
);

// File: tb/bytelane_sram_test.sv
module bytelane_sram_test;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int TOP_A = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          sel_n = 1'b1, wr_n = 1'b1, rden_n = 1'b1;
  logic [1:0]    lane_en_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [1:0]    lane_drv;
  logic [1:0]    op_mode;
  logic          idle_pwr;

  bytelane_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .rden_n(rden_n),
    .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .lane_drv(lane_drv), .op_mode(op_mode), .idle_pwr(idle_pwr)
  );

  typedef struct {
    logic s, w, r;
    logic [1:0] b;
    int a;
    logic [15:0] d;
    string tag;
  } vec_t;

  vec_t h1, h2, h3;
  logic [15:0] mref [int];
  int tests = 0;
  int fails = 0;

  function automatic int exp_mode(vec_t v);
    if (v.s) return 0;
    if (v.b == 2'b11) return 1;
    if (!v.w) return 3;
    if (!v.r) return 2;
    return 1;
  endfunction

  function automatic logic ovl(vec_t v, int i);
    return !v.s && !v.w && !v.b[i];
  endfunction

  function automatic vec_t mk(logic s, logic w, logic r, logic [1:0] b, int a,
                              logic [15:0] d, string tag);
    vec_t v;
    v.s = s; v.w = w; v.r = r; v.b = b; v.a = a; v.d = d; v.tag = tag;
    return v;
  endfunction

  // Compare outputs against the vector sampled two edges ago, then apply its write
  task automatic check_outputs();
    int em;
    logic [1:0] edrv;
    logic [15:0] word, edata;
    em = exp_mode(h2);
    edrv = (em == 2) ? ~h2.b : 2'b00;
    word = mref.exists(h2.a) ? mref[h2.a] : 16'h0000;
    edata = {edrv[1] ? word[15:8] : 8'h00, edrv[0] ? word[7:0] : 8'h00};
    tests++;
    if (op_mode !== 2'(em) || lane_drv !== edrv || idle_pwr !== (em == 0) || rdata !== edata) begin
      fails++;
      $display("FAIL %s: got mode=%0d drv=%b idle=%b data=%h, expected mode=%0d drv=%b idle=%b data=%h",
               h2.tag, op_mode, lane_drv, idle_pwr, rdata, em, edrv, (em == 0), edata);
    end
    for (int i = 0; i < 2; i++) begin
      if (ovl(h2, i) && !ovl(h3, i)) begin
        word = mref.exists(h2.a) ? mref[h2.a] : 16'h0000;
        word[i*8 +: 8] = h2.d[i*8 +: 8];
        mref[h2.a] = word;
      end
    end
  endtask

  task automatic step(logic s, logic w, logic r, logic [1:0] b, int a,
                      logic [15:0] d, string tag);
    @(negedge clk);
    check_outputs();
    h3 = h2;
    h2 = h1;
    h1 = mk(s, w, r, b, a, d, tag);
    sel_n = s; wr_n = w; rden_n = r; lane_en_n = b; addr = AW'(a); wdata = d;
  endtask

  task automatic idle(string tag);
    step(1'b1, 1'b1, 1'b1, 2'b11, 0, 16'h0000, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    h1 = mk(1, 1, 1, 2'b11, 0, 0, "R9");
    h2 = h1;
    h3 = h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (op_mode !== 2'd0 || lane_drv !== 2'b00 || idle_pwr !== 1'b1 || rdata !== 16'h0000) begin
      fails++;
      $display("FAIL R9: got mode=%0d drv=%b idle=%b data=%h, expected mode=0 drv=00 idle=1 data=0000",
               op_mode, lane_drv, idle_pwr, rdata);
    end
    rst = 1'b0;

    // R1: full-word writes, each a separate strobe, then readback
    for (int a = 0; a < 16; a++) begin
      step(0, 0, 1, 2'b00, a, 16'(a * 16'h0373 + 16'h1234), "R1");
      step(0, 1, 1, 2'b00, a, 16'h0000, "R7");
    end
    step(0, 0, 1, 2'b00, TOP_A, 16'hC3A5, "R1");
    step(0, 1, 1, 2'b00, TOP_A, 16'h0000, "R7");
    for (int a = 0; a < 16; a++) step(0, 1, 0, 2'b00, a, 16'h0000, "R1");
    step(0, 1, 0, 2'b00, TOP_A, 16'h0000, "R1");

    // R8: read right after a write sees new data
    step(0, 0, 1, 2'b00, 3, 16'h5A5A, "R8");
    step(0, 1, 0, 2'b00, 3, 16'h0000, "R8");

    // R4: single-lane writes keep the other lane
    step(0, 0, 1, 2'b10, 4, 16'hBEEF, "R4");
    step(0, 1, 1, 2'b00, 4, 16'h0000, "R4");
    step(0, 1, 0, 2'b00, 4, 16'h0000, "R4");
    step(0, 0, 1, 2'b01, 5, 16'hCAFE, "R4");
    step(0, 1, 1, 2'b00, 5, 16'h0000, "R4");
    step(0, 1, 0, 2'b00, 5, 16'h0000, "R4");

    // R6: single-lane reads
    step(0, 1, 0, 2'b10, 4, 16'h0000, "R6");
    step(0, 1, 0, 2'b01, 4, 16'h0000, "R6");
    step(0, 1, 0, 2'b01, 5, 16'h0000, "R6");

    // R7: outputs off, and a write with both lanes disabled
    step(0, 1, 1, 2'b00, 4, 16'h0000, "R7");
    step(0, 1, 0, 2'b11, 4, 16'h0000, "R7");
    step(0, 0, 0, 2'b11, 6, 16'hDEAD, "R7");
    step(0, 1, 1, 2'b00, 6, 16'h0000, "R7");
    step(0, 1, 0, 2'b00, 6, 16'h0000, "R7");

    // R2: deselected write is ignored
    step(1, 0, 0, 2'b00, 7, 16'hFFFF, "R2");
    step(1, 1, 0, 2'b00, 7, 16'h0000, "R2");
    step(0, 1, 0, 2'b00, 7, 16'h0000, "R2");

    // R3: write with read enable low, then readback
    step(0, 0, 0, 2'b00, 8, 16'h8888, "R3");
    step(0, 1, 1, 2'b00, 8, 16'h0000, "R3");
    step(0, 1, 0, 2'b00, 8, 16'h0000, "R3");

    // R5: unbroken overlap commits once; lane joining late commits its byte
    step(0, 0, 1, 2'b00, 9, 16'h9999, "R5");
    step(0, 0, 1, 2'b00, 10, 16'h1010, "R5");
    step(0, 0, 1, 2'b00, 9, 16'h0000, "R5");
    step(0, 1, 1, 2'b00, 9, 16'h0000, "R5");
    step(0, 1, 0, 2'b00, 9, 16'h0000, "R5");
    step(0, 1, 0, 2'b00, 10, 16'h0000, "R5");
    step(0, 0, 1, 2'b10, 11, 16'h1111, "R5");
    step(0, 0, 1, 2'b00, 11, 16'h2222, "R5");
    step(0, 1, 1, 2'b00, 11, 16'h0000, "R5");
    step(0, 1, 0, 2'b00, 11, 16'h0000, "R5");

    // Mixed random traffic over written addresses
    for (int n = 0; n < 400; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[0] & rv[1], rv[2], rv[3], rv[5:4], int'(rv[11:8]), rv[31:16], "R8");
    end

    repeat (3) idle("R2");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule